// File: doc/BRIEF.md
# LED Pulse-Width and Blink Generator

This block computes the on/off level of 32 LED pins, one bit per pin, for a serial shift engine that sits beside it and carries the bits off chip. Each pin's brightness is set by an 8-bit duty value. The duty value is compared against a free-running 8-bit counter. A pin can also be told to blink. A blinking pin has its pulse-width level gated by a 50% square wave from one of nine blink sources.

Two tick inputs drive the blink sources. One is a fixed-rate tick and the other is a timer tick. Each of these two ticks feeds four dividers. The dividers divide the tick count by 800, 1000, 2000 or 4000. A ninth source toggles on every timer tick with no division. The eight upper pins (24 to 31) each have their own 6-bit blink setting. The 24 lower pins all share a single setting.

A change to a blink setting does not take effect at once. It waits for the next terminal count of the wave the pin is currently using, so the wave is never cut short.

Top module: `ledBlinkGen`

## Requirements
- R1: Register map, by word address. Addresses 0 to 31 hold the duty values of pins 0 to 31 in bits [7:0]. Address 32 holds the 32-bit blink mask, bit p for pin p. Address 35 holds the shared 6-bit setting in bits [5:0]. A read returns the stored value with unused bits at zero. Any address from 36 up reads as zero, and a write to it changes nothing.
- R2: The pulse-width counter starts at 0 after reset and increments by one every clock, wrapping at 256. A pin that is not blinking is high when its duty is 255. Otherwise it is high exactly while the counter is below its duty. A duty of 0 keeps the pin low.
- R3: During and directly after reset, every duty value, the mask and every blink setting read as 0, and all 32 outputs are low.
- R4: A divider counts the ticks of its source. Rate index 0, 1, 2 and 3 select a divisor of 4000, 2000, 1000 and 800 ticks. When the last tick of a count arrives, the divider's wave toggles. Every wave is high after reset.
- R5: A 6-bit blink setting holds the source-0 rate index in bits [1:0], the source-1 rate index in bits [3:2] and the source select in bits [5:4]. Select 0 uses the divided fixed tick, select 1 the divided timer tick, and select 2 or 3 a wave that toggles on every timer tick.
- R6: A pin whose mask bit is 1 outputs its pulse-width level ANDed with its selected wave. A pin whose mask bit is 0 outputs its pulse-width level alone.
- R7: Address 33 holds the settings of pins 24 to 28, pin 24+k at bits [6k+5:6k]. Address 34 holds pins 29 to 31, pin 29+k at bits [6k+5:6k].
- R8: Pins 0 to 23 all use the setting at address 35. They have no fields of their own.
- R9: After a setting is written, its pins keep their current wave until that wave's next terminal count. From the following clock on, they use the wave named by the setting as it stood at that terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fixTick | input | 1 | One-cycle tick of the fixed blink source |
| tmrTick | input | 1 | One-cycle tick of the timer blink source |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| ledOut | output | 32 | Modulated level per pin |

## Verification
Every result is due one clock edge after its cause. A register write, a tick or a counter step at one edge changes `ledOut` and `regRdata` for the cycle that follows. `regRdata` also follows the address in the same cycle. The bench runs a behavioural model that takes each edge's inputs and steps its integer counters, waves and pending selections in the same way. It compares both outputs at the falling edge after every rising edge, on every clock. This covers the terminal-count cycle in which a deferred blink setting takes hold, and it catches a one-cycle shift anywhere.

// File: rtl/ledBlinkPkg.sv
package ledBlinkPkg;
  localparam int NUM_PINS    = 32;
  localparam int SHARED_PINS = 24;
  localparam int NUM_SLOTS   = NUM_PINS - SHARED_PINS + 1;
  localparam int LO_PINS     = 5;
  localparam int HI_PINS     = NUM_SLOTS - 1 - LO_PINS;
  localparam int DUTY_W      = 8;
  localparam int CFG_W       = 6;
  localparam int NUM_RATES   = 4;
  localparam int NUM_WAVES   = 2 * NUM_RATES + 1;
  localparam int WAVE_IDX_W  = $clog2(NUM_WAVES);
  localparam int ADDR_W      = 6;
  localparam int DATA_W      = 32;
  localparam int ADDR_MASK   = NUM_PINS;
  localparam int ADDR_CFG_LO = NUM_PINS + 1;
  localparam int ADDR_CFG_HI = NUM_PINS + 2;
  localparam int ADDR_CFG_SH = NUM_PINS + 3;
  localparam int unsigned RATE_DIV [NUM_RATES] = '{4000, 2000, 1000, 800};
  localparam int DIV_CNT_W   = $clog2(4000);

  typedef enum logic [1:0] {
    SRC_FIX      = 2'd0,
    SRC_TMR      = 2'd1,
    SRC_FAST     = 2'd2,
    SRC_FAST_ALT = 2'd3
  } blinkSrc_e;

  // strobes from the timebase to the pin datapath
  typedef struct packed {
    logic [DUTY_W-1:0]    pwmCnt;
    logic [NUM_WAVES-1:0] wave;
    logic [NUM_WAVES-1:0] term;
  } tbStrb_t;

  // wave index: 0..3 fixed-tick rates, 4..7 timer rates, 8 undivided timer
  function automatic logic [WAVE_IDX_W-1:0] waveIndex(input logic [CFG_W-1:0] cfg);
    logic [WAVE_IDX_W-1:0] idx;
    case (blinkSrc_e'(cfg[5:4]))
      SRC_FIX: idx = WAVE_IDX_W'(cfg[1:0]);
      SRC_TMR: idx = WAVE_IDX_W'(NUM_RATES) + WAVE_IDX_W'(cfg[3:2]);
      default: idx = WAVE_IDX_W'(NUM_WAVES - 1);
    endcase
    return idx;
  endfunction
endpackage

// File: rtl/ledTimebase.sv
module ledTimebase
  import ledBlinkPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    fixTick,
  input  logic    tmrTick,
  output tbStrb_t strb
);
  logic [DUTY_W-1:0]    pwmCnt;
  logic [NUM_WAVES-1:0] waveVec;
  logic [NUM_WAVES-1:0] termVec;
  logic                 fastWave;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwmCnt <= '0;
    else       pwmCnt <= pwmCnt + 1'b1;
  end

  for (genvar g = 0; g < 2 * NUM_RATES; g++) begin : g_div
    localparam logic [DIV_CNT_W-1:0] LAST = DIV_CNT_W'(RATE_DIV[g % NUM_RATES] - 1);
    logic srcTick;
    logic [DIV_CNT_W-1:0] cnt;
    logic wv;
    if (g < NUM_RATES) begin : g_fix
      assign srcTick = fixTick;
    end else begin : g_tmr
      assign srcTick = tmrTick;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt <= '0;
        wv  <= 1'b1;
      end else if (srcTick) begin
        if (cnt == LAST) begin
          cnt <= '0;
          wv  <= ~wv;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign termVec[g] = srcTick && (cnt == LAST);
    assign waveVec[g] = wv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        fastWave <= 1'b1;
    else if (tmrTick) fastWave <= ~fastWave;
  end
  assign termVec[NUM_WAVES-1] = tmrTick;
  assign waveVec[NUM_WAVES-1] = fastWave;

  assign strb = '{pwmCnt: pwmCnt, wave: waveVec, term: termVec};
endmodule

// File: rtl/ledPinPath.sv
module ledPinPath
  import ledBlinkPkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  tbStrb_t                          strb,
  input  logic                             regWe,
  input  logic [ADDR_W-1:0]                regAddr,
  input  logic [DATA_W-1:0]                regWdata,
  output logic [DATA_W-1:0]                regRdata,
  output logic [NUM_PINS-1:0]              ledOut,
  output logic [NUM_PINS*DUTY_W-1:0]       dutyFlat,
  output logic [NUM_PINS-1:0]              maskOut,
  output logic [NUM_SLOTS*WAVE_IDX_W-1:0]  effFlat
);
  logic [DUTY_W-1:0]     duty   [NUM_PINS];
  logic [NUM_PINS-1:0]   blinkMask;
  logic [CFG_W-1:0]      cfgSlot[NUM_SLOTS];
  logic [WAVE_IDX_W-1:0] effIdx [NUM_SLOTS];

  // register bank; slot 0 is shared by the lower pins, slot k by pin SHARED_PINS+k-1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blinkMask <= '0;
      for (int p = 0; p < NUM_PINS; p++) duty[p] <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) cfgSlot[s] <= '0;
    end else if (regWe) begin
      for (int p = 0; p < NUM_PINS; p++)
        if (regAddr == ADDR_W'(p)) duty[p] <= regWdata[DUTY_W-1:0];
      if (regAddr == ADDR_W'(ADDR_MASK)) blinkMask <= regWdata[NUM_PINS-1:0];
      if (regAddr == ADDR_W'(ADDR_CFG_LO))
        for (int k = 0; k < LO_PINS; k++) cfgSlot[1+k] <= regWdata[k*CFG_W +: CFG_W];
      if (regAddr == ADDR_W'(ADDR_CFG_HI))
        for (int k = 0; k < HI_PINS; k++) cfgSlot[1+LO_PINS+k] <= regWdata[k*CFG_W +: CFG_W];
      if (regAddr == ADDR_W'(ADDR_CFG_SH)) cfgSlot[0] <= regWdata[CFG_W-1:0];
    end
  end

  always_comb begin
    regRdata = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (regAddr == ADDR_W'(p)) regRdata[DUTY_W-1:0] = duty[p];
    if (regAddr == ADDR_W'(ADDR_MASK)) regRdata[NUM_PINS-1:0] = blinkMask;
    if (regAddr == ADDR_W'(ADDR_CFG_LO))
      for (int k = 0; k < LO_PINS; k++) regRdata[k*CFG_W +: CFG_W] = cfgSlot[1+k];
    if (regAddr == ADDR_W'(ADDR_CFG_HI))
      for (int k = 0; k < HI_PINS; k++) regRdata[k*CFG_W +: CFG_W] = cfgSlot[1+LO_PINS+k];
    if (regAddr == ADDR_W'(ADDR_CFG_SH)) regRdata[CFG_W-1:0] = cfgSlot[0];
  end

  // effective wave per slot, swapped only on the terminal count of the wave in use
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) effIdx[s] <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++)
        if (strb.term[effIdx[s]]) effIdx[s] <= waveIndex(cfgSlot[s]);
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int SLOT = (p < SHARED_PINS) ? 0 : p - SHARED_PINS + 1;
    logic pwmOn;
    assign pwmOn     = (duty[p] == {DUTY_W{1'b1}}) || (strb.pwmCnt < duty[p]);
    assign ledOut[p] = blinkMask[p] ? (pwmOn & strb.wave[effIdx[SLOT]]) : pwmOn;
    assign dutyFlat[p*DUTY_W +: DUTY_W] = duty[p];
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_flat
    assign effFlat[s*WAVE_IDX_W +: WAVE_IDX_W] = effIdx[s];
  end

  assign maskOut = blinkMask;
endmodule

// File: rtl/ledBlinkGen.sv
module ledBlinkGen
  import ledBlinkPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                fixTick,
  input  logic                tmrTick,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  output logic [NUM_PINS-1:0] ledOut
);
  tbStrb_t                          strb;
  logic [NUM_PINS*DUTY_W-1:0]       dutyFlat;
  logic [NUM_PINS-1:0]              maskOut;
  logic [NUM_SLOTS*WAVE_IDX_W-1:0]  effFlat;

  ledTimebase uTime (
    .clk(clk), .rstN(rstN), .fixTick(fixTick), .tmrTick(tmrTick), .strb(strb)
  );

  ledPinPath uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .ledOut(ledOut),
    .dutyFlat(dutyFlat), .maskOut(maskOut), .effFlat(effFlat)
  );
endmodule

// File: rtl/ledBlinkChk.sv
module ledBlinkChk
  import ledBlinkPkg::*;
(
  input logic                             clk,
  input logic                             rstN,
  input logic                             tmrTick,
  input tbStrb_t                          strb,
  input logic [NUM_PINS-1:0]              ledOut,
  input logic [NUM_PINS-1:0]              maskOut,
  input logic [NUM_PINS*DUTY_W-1:0]       dutyFlat,
  input logic [NUM_SLOTS*WAVE_IDX_W-1:0]  effFlat
);
  p_pwm_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> strb.pwmCnt == $past(strb.pwmCnt) + 1'b1);

  p_fast_toggle_r5: assert property (@(posedge clk) disable iff (!rstN)
    tmrTick |=> strb.wave[NUM_WAVES-1] != $past(strb.wave[NUM_WAVES-1]));

  for (genvar g = 0; g < NUM_WAVES; g++) begin : g_wave
    p_wave_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
      !strb.term[g] |=> $stable(strb.wave[g]));
    p_wave_flip_r4: assert property (@(posedge clk) disable iff (!rstN)
      strb.term[g] |=> strb.wave[g] != $past(strb.wave[g]));
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    p_eff_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      !strb.term[effFlat[s*WAVE_IDX_W +: WAVE_IDX_W]] |=> $stable(effFlat[s*WAVE_IDX_W +: WAVE_IDX_W]));
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int SLOT = (p < SHARED_PINS) ? 0 : p - SHARED_PINS + 1;
    p_dark_r2: assert property (@(posedge clk) disable iff (!rstN)
      dutyFlat[p*DUTY_W +: DUTY_W] == '0 |-> !ledOut[p]);
    p_full_r2: assert property (@(posedge clk) disable iff (!rstN)
      (dutyFlat[p*DUTY_W +: DUTY_W] == {DUTY_W{1'b1}}) && !maskOut[p] |-> ledOut[p]);
    p_blink_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
      maskOut[p] && !strb.wave[effFlat[SLOT*WAVE_IDX_W +: WAVE_IDX_W]] |-> !ledOut[p]);
  end
endmodule

bind ledBlinkGen ledBlinkChk uChk (
  .clk(clk), .rstN(rstN), .tmrTick(tmrTick), .strb(strb), .ledOut(ledOut),
  .maskOut(maskOut), .dutyFlat(dutyFlat), .effFlat(effFlat)
);

// File: tb/tb_ledBlinkGen.sv
`timescale 1ns/1ps
module tb_ledBlinkGen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fixTick = 1'b0, tmrTick = 1'b0, regWe = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] ledOut;

  always #2.5 clk = ~clk;

  ledBlinkGen dut (.clk(clk), .rstN(rstN), .fixTick(fixTick), .tmrTick(tmrTick),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .ledOut(ledOut));

  // behavioural reference
  int          mDuty [32];
  logic [31:0] mMask;
  logic [5:0]  mCfg  [9];
  int          mCnt  [8];
  logic        mWave [9];
  int          mEff  [9];
  int          mPwm;
  int          divs  [4] = '{4000, 2000, 1000, 800};

  int    vectors = 0, errors = 0;
  bit    done = 0;
  string phase = "R3 reset";

  function automatic int selOf(logic [5:0] c);
    if (c[5:4] == 2'd0) return int'(c[1:0]);
    if (c[5:4] == 2'd1) return 4 + int'(c[3:2]);
    return 8;
  endfunction

  function automatic logic expLed(int p);
    logic pw;
    int   slot;
    pw   = (mDuty[p] == 255) || (mPwm < mDuty[p]);
    slot = (p < 24) ? 0 : p - 23;
    return mMask[p] ? (pw & mWave[mEff[slot]]) : pw;
  endfunction

  function automatic logic [31:0] expRd(logic [5:0] a);
    logic [31:0] r = '0;
    if (a < 32) r[7:0] = 8'(mDuty[a]);
    else if (a == 32) r = mMask;
    else if (a == 33) for (int k = 0; k < 5; k++) r[6*k +: 6] = mCfg[1+k];
    else if (a == 34) for (int k = 0; k < 3; k++) r[6*k +: 6] = mCfg[6+k];
    else if (a == 35) r[5:0] = mCfg[0];
    return r;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 32; i++) mDuty[i] = 0;
    mMask = '0;
    for (int i = 0; i < 9; i++) begin mCfg[i] = '0; mWave[i] = 1'b1; mEff[i] = 0; end
    for (int i = 0; i < 8; i++) mCnt[i] = 0;
    mPwm = 0;
  endtask

  task automatic modelStep(logic fx, logic tm, logic we, logic [5:0] a, logic [31:0] d);
    logic term [9];
    for (int g = 0; g < 8; g++) term[g] = ((g < 4) ? fx : tm) && (mCnt[g] == divs[g % 4] - 1);
    term[8] = tm;
    for (int s = 0; s < 9; s++) if (term[mEff[s]]) mEff[s] = selOf(mCfg[s]);
    for (int g = 0; g < 8; g++)
      if ((g < 4) ? fx : tm) begin
        if (term[g]) begin mCnt[g] = 0; mWave[g] = ~mWave[g]; end
        else mCnt[g]++;
      end
    if (tm) mWave[8] = ~mWave[8];
    mPwm = (mPwm + 1) % 256;
    if (we) begin
      if (a < 32) mDuty[a] = int'(d[7:0]);
      else if (a == 32) mMask = d;
      else if (a == 33) for (int k = 0; k < 5; k++) mCfg[1+k] = d[6*k +: 6];
      else if (a == 34) for (int k = 0; k < 3; k++) mCfg[6+k] = d[6*k +: 6];
      else if (a == 35) mCfg[0] = d[5:0];
    end
  endtask

  // compare both outputs; tags: R1 readback, R2 steady pins, R8 shared-slot blink, R7 upper-pin blink
  task automatic compare();
    logic [31:0] eRd = expRd(regAddr);
    vectors += 2;
    for (int p = 0; p < 32; p++)
      if (ledOut[p] !== expLed(p)) begin
        errors++;
        $display("FAIL %s %s pin %0d: ledOut got %b exp %b", phase,
                 !mMask[p] ? "R2" : (p < 24 ? "R8" : "R7"), p, ledOut[p], expLed(p));
        break;
      end
    if (regRdata !== eRd) begin
      errors++;
      $display("FAIL %s R1 addr %0d: regRdata got %h exp %h", phase, regAddr, regRdata, eRd);
    end
  endtask

  task automatic step(logic fx, logic tm, logic we, logic [5:0] a, logic [31:0] d);
    compare();
    fixTick = fx; tmrTick = tm; regWe = we; regAddr = a; regWdata = d;
    if (rstN) modelStep(fx, tm, we, a, d);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n, int fxMode, int tmMode);
    for (int i = 0; i < n; i++)
      step(fxMode == 2 ? 1'($urandom) : 1'(fxMode), tmMode == 2 ? 1'($urandom) : 1'(tmMode),
           1'b0, 6'(i % 40), '0);
  endtask

  function automatic logic [5:0] cfg(int src, int r0, int r1);
    return {2'(src), 2'(r1), 2'(r0)};
  endfunction

  initial begin
    modelReset();
    @(negedge clk);
    // R3: held in reset, then just released
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 6'(i * 11), 32'hFFFF_FFFF);
    rstN = 1'b1;
    idle(3, 0, 0);

    phase = "R1 regs";
    for (int p = 0; p < 32; p++) step(1'b0, 1'b0, 1'b1, 6'(p), 32'hABCD_0000 | 32'(p * 8 + 1));
    step(1'b0, 1'b0, 1'b1, 6'd40, 32'hFFFF_FFFF);  // ignored address
    step(1'b0, 1'b0, 1'b1, 6'd63, 32'h1234_5678);
    for (int a = 0; a < 64; a++) step(1'b0, 1'b0, 1'b0, 6'(a), '0);

    phase = "R2 pwm";
    step(1'b0, 1'b0, 1'b1, 6'd0, 32'd0);
    step(1'b0, 1'b0, 1'b1, 6'd1, 32'd255);
    step(1'b0, 1'b0, 1'b1, 6'd2, 32'd1);
    step(1'b0, 1'b0, 1'b1, 6'd3, 32'd254);
    step(1'b0, 1'b0, 1'b1, 6'd4, 32'd128);
    idle(600, 0, 0);

    phase = "R4 R5 R7 R8 blink";
    step(1'b1, 1'b0, 1'b1, 6'd32, 32'hFFFF_FFFF);
    step(1'b1, 1'b0, 1'b1, 6'd35, 32'(cfg(0, 3, 0)));
    step(1'b1, 1'b0, 1'b1, 6'd33, {2'b0, cfg(1, 0, 3), cfg(1, 0, 0), cfg(0, 2, 0), cfg(0, 1, 0), cfg(0, 0, 0)});
    step(1'b1, 1'b0, 1'b1, 6'd34, {14'b0, cfg(1, 0, 2), cfg(3, 0, 0), cfg(2, 0, 0)});
    for (int p = 0; p < 32; p++) step(1'b1, 1'($urandom), 1'b1, 6'(p), 32'd255);
    idle(9000, 1, 2);

    phase = "R9 switch";
    step(1'b1, 1'b1, 1'b1, 6'd35, 32'(cfg(1, 0, 1)));
    idle(3000, 1, 1);
    step(1'b1, 1'b1, 1'b1, 6'd35, 32'(cfg(2, 0, 0)));
    step(1'b1, 1'b1, 1'b1, 6'd33, 32'($urandom));
    idle(5000, 1, 1);
    step(1'b1, 1'b0, 1'b1, 6'd35, 32'(cfg(0, 2, 0)));
    idle(4500, 1, 0);

    phase = "R6 mixed";
    for (int i = 0; i < 6000; i++) begin
      int pick = int'($urandom % 50);
      if (pick < 36) step(1'($urandom), 1'($urandom), 1'b1, 6'(pick), $urandom);
      else step(1'($urandom), 1'($urandom), 1'b0, 6'($urandom % 64), '0);
    end
    compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule